// File: doc/BRIEF.md
# Banked Coder State Swap Unit

This block holds the working registers of a bank of arithmetic coders for the code-block being coded now, and exchanges them with an external state memory so that coding can hop between many code-blocks from one stripe to the next. The state is split into banks, one per magnitude bit-plane. Every bank keeps two copies. The active copy is read and written by the coders through a word-wide access port. The idle copy is emptied and refilled as a chain of 16-bit words, one bank at a time.

A block-switch strobe swaps the roles of the two copies. The copy that just became idle then pushes the state of the block that is leaving out to memory, word by word, while the state of the next block shifts in from the other end of the same chain. A block being coded for the first time is filled with fixed start values and nothing is read from memory. A block that has finished is not written back. Instead, each of its bit-plane streams is flushed in a single cycle, and this happens while the next block is loading. The whole exchange fits inside a 256-cycle stripe period.

Top module: `coder_state_swap`

## Requirements
- R1: After reset, `xfer_busy`, `mem_rd_en`, `mem_wr_en` and `flush_valid` are low, and every word read through the coder port is 0. Memory enables are only ever high while `xfer_busy` is high.
- R2: A coder write to (bank, word) changes only the active copy. The new value is returned by a coder read of the same bank and word from the next cycle on.
- R3: `blk_switch` is accepted only while `xfer_busy` is low. A strobe raised during a transfer is ignored: the active copy stays the same and the running transfer is not restarted.
- R4: An accepted switch makes the copy filled by the previous transfer the active one, so coder reads then return that block's state.
- R5: `xfer_busy` rises in the cycle after an accepted switch and stays high for exactly 251 cycles. These are one read-priming cycle followed by 250 shift cycles, 25 words for each of 10 banks.
- R6: A block's memory region starts at word address index×250. Loading reads addresses base+0 to base+249 in ascending order, one word per cycle. Word k lands in bank k/25 at word k mod 25.
- R7: When the outgoing copy holds a loaded block and `cur_finish` was low at the switch, its 250 words are written to that block's own region in ascending address order, using the same word-to-bank mapping as R6.
- R8: When `nxt_first` is high at the switch, no memory reads are made. Each bank of the incoming state is set to 0x8000 in word 0 and 0 in words 1 to 24.
- R9: When `cur_finish` is high at the switch, no memory writes are made. Instead, `flush_valid` pulses once for each bank, in banks 0 to 9 ascending order, on that bank's first shift cycle. `flush_bank` gives the bank and `flush_data` gives word 0 of the outgoing copy of that bank.
- R10: An outgoing copy that has never been loaded since reset is neither stored nor flushed.
- R11: During a transfer, coder reads of the active copy are unaffected by the shifting of the idle copy. Only one bank shifts in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cdr_wr_en | input | 1 | Coder write strobe to active copy |
| cdr_wr_bank | input | 4 | Bank of the coder write |
| cdr_wr_word | input | 5 | Word within bank of the coder write |
| cdr_wr_data | input | 16 | Coder write data |
| cdr_rd_bank | input | 4 | Bank of the coder read |
| cdr_rd_word | input | 5 | Word within bank of the coder read |
| cdr_rd_data | output | 16 | Active-copy read data (combinational) |
| blk_switch | input | 1 | Block-switch strobe |
| nxt_blk | input | 4 | Index of the block to load |
| nxt_first | input | 1 | Block to load is coded for the first time |
| cur_finish | input | 1 | Block leaving the active copy has finished |
| xfer_busy | output | 1 | Transfer in progress |
| mem_rd_en | output | 1 | State memory read request |
| mem_rd_addr | output | 12 | State memory read address |
| mem_rd_data | input | 16 | Read data, one cycle after the request |
| mem_wr_en | output | 1 | State memory write strobe |
| mem_wr_addr | output | 12 | State memory write address |
| mem_wr_data | output | 16 | State memory write data |
| flush_valid | output | 1 | Flush pulse for one bit-plane stream |
| flush_bank | output | 4 | Bank being flushed |
| flush_data | output | 16 | Word 0 of the flushed bank |

## Verification
The transfer is run with four kinds of switch. A first-use load with an outgoing copy that was never loaded shows the start values and that nothing is stored or flushed. A plain memory load followed by a store shows that the addresses and the word-to-bank mapping survive a round trip, including a word the coder modified. A finish combined with a first-use load shows that the flush replaces the store and that the memory region is left untouched. A second strobe raised in the middle of a transfer, together with coder reads taken while the idle copy is shifting, shows that the active copy and the 251-cycle transfer length are not disturbed.

// File: rtl/cstate_pkg.sv
package cstate_pkg;
   typedef enum logic [1:0] {
      XF_IDLE  = 2'd0,
      XF_PRIME = 2'd1,
      XF_SHIFT = 2'd2
   } xfer_state_e;

   function automatic int unsigned need_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/cstate_bank.sv
module cstate_bank #(
   parameter int WORD_W     = 16,
   parameter int BANK_WORDS = 25,
   parameter int WIDX_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_sel,
   input  logic              wr_en,
   input  logic [WIDX_W-1:0] wr_word,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [WIDX_W-1:0] rd_word,
   output logic [WORD_W-1:0] rd_data,
   input  logic              sh_en,
   input  logic [WORD_W-1:0] sh_in,
   output logic [WORD_W-1:0] head
);
   logic [WORD_W-1:0] copy_rd   [2];
   logic [WORD_W-1:0] copy_head [2];
   logic              wr_ok, rd_ok;

   assign wr_ok = (32'(wr_word) < BANK_WORDS);
   assign rd_ok = (32'(rd_word) < BANK_WORDS);

   for (genvar c = 0; c < 2; c++) begin : g_copy
      logic [WORD_W-1:0] cp [BANK_WORDS];
      logic              is_act;
      assign is_act = (act_sel == 1'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < BANK_WORDS; w++) cp[w] <= '0;
         end else if (is_act) begin
            if (wr_en && wr_ok) cp[wr_word] <= wr_data;
         end else if (sh_en) begin
            for (int w = 0; w < BANK_WORDS - 1; w++) cp[w] <= cp[w+1];
            cp[BANK_WORDS-1] <= sh_in;
         end
      end

      assign copy_rd[c]   = rd_ok ? cp[rd_word] : '0;
      assign copy_head[c] = cp[0];
   end

   assign rd_data = copy_rd[act_sel];
   assign head    = copy_head[~act_sel];
endmodule

// File: rtl/cstate_xfer_seq.sv
module cstate_xfer_seq
   import cstate_pkg::*;
#(
   parameter int BANKS      = 10,
   parameter int BANK_WORDS = 25,
   parameter int BLK_W      = 4,
   parameter int ADDR_W     = 12,
   parameter int BANK_W     = 4,
   parameter int WIDX_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_req,
   input  logic [BLK_W-1:0]  ld_idx,
   input  logic              ld_first,
   input  logic              st_finish,
   output logic              busy,
   output logic              act_sel,
   output logic              sh_en,
   output logic [BANK_W-1:0] sh_bank,
   output logic [WIDX_W-1:0] sh_word,
   output logic              use_init,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              flush_valid
);
   localparam int XFER_WORDS = BANKS * BANK_WORDS;
   localparam int K_W        = need_bits(XFER_WORDS);

   xfer_state_e       state_q;
   logic [K_W-1:0]    k_q;
   logic [BANK_W-1:0] bank_q;
   logic [WIDX_W-1:0] word_q;
   logic [ADDR_W-1:0] ld_base_q, st_base_q;
   logic              first_q, store_q, flush_q;
   logic [BLK_W-1:0]  tag_q [2];
   logic [1:0]        val_q;
   logic              last_k, last_w, accept;

   function automatic logic [ADDR_W-1:0] base_of(input logic [BLK_W-1:0] idx);
      return ADDR_W'(idx) * ADDR_W'(XFER_WORDS);
   endfunction

   assign accept = sw_req && (state_q == XF_IDLE);
   assign last_k = (32'(k_q) == XFER_WORDS - 1);
   assign last_w = (32'(word_q) == BANK_WORDS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= XF_IDLE;
         act_sel   <= 1'b0;
         k_q       <= '0;
         bank_q    <= '0;
         word_q    <= '0;
         ld_base_q <= '0;
         st_base_q <= '0;
         first_q   <= 1'b0;
         store_q   <= 1'b0;
         flush_q   <= 1'b0;
         tag_q[0]  <= '0;
         tag_q[1]  <= '0;
         val_q     <= '0;
      end else begin
         unique case (state_q)
            XF_IDLE: if (accept) begin
               act_sel        <= ~act_sel;
               st_base_q      <= base_of(tag_q[act_sel]);
               store_q        <= val_q[act_sel] & ~st_finish;
               flush_q        <= val_q[act_sel] & st_finish;
               ld_base_q      <= base_of(ld_idx);
               first_q        <= ld_first;
               tag_q[act_sel] <= ld_idx;
               val_q[act_sel] <= 1'b1;
               k_q            <= '0;
               bank_q         <= '0;
               word_q         <= '0;
               state_q        <= XF_PRIME;
            end
            XF_PRIME: state_q <= XF_SHIFT;
            XF_SHIFT: begin
               k_q <= k_q + 1'b1;
               if (last_w) begin
                  word_q <= '0;
                  bank_q <= bank_q + 1'b1;
               end else begin
                  word_q <= word_q + 1'b1;
               end
               if (last_k) state_q <= XF_IDLE;
            end
            default: state_q <= XF_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != XF_IDLE);
   assign sh_en       = (state_q == XF_SHIFT);
   assign sh_bank     = bank_q;
   assign sh_word     = word_q;
   assign use_init    = first_q;
   assign rd_en       = !first_q &&
                        ((state_q == XF_PRIME) || ((state_q == XF_SHIFT) && !last_k));
   assign rd_addr     = ld_base_q + ((state_q == XF_PRIME) ? '0 : (ADDR_W'(k_q) + 1'b1));
   assign wr_en       = sh_en && store_q;
   assign wr_addr     = st_base_q + ADDR_W'(k_q);
   assign flush_valid = sh_en && flush_q && (word_q == '0);
endmodule

// File: rtl/coder_state_swap.sv
module coder_state_swap
   import cstate_pkg::*;
#(
   parameter int              NUM_BANKS     = 10,
   parameter int              BANK_WORDS    = 25,
   parameter int              WORD_W        = 16,
   parameter int              NUM_BLOCKS    = 13,
   parameter int              BLK_W         = 4,
   parameter int              ADDR_W        = 12,
   parameter int              STRIPE_CYCLES = 256,
   parameter logic [WORD_W-1:0] INIT_HEAD   = 16'h8000,
   localparam int             BANK_W        = need_bits(NUM_BANKS),
   localparam int             WIDX_W        = need_bits(BANK_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cdr_wr_en,
   input  logic [BANK_W-1:0] cdr_wr_bank,
   input  logic [WIDX_W-1:0] cdr_wr_word,
   input  logic [WORD_W-1:0] cdr_wr_data,
   input  logic [BANK_W-1:0] cdr_rd_bank,
   input  logic [WIDX_W-1:0] cdr_rd_word,
   output logic [WORD_W-1:0] cdr_rd_data,
   input  logic              blk_switch,
   input  logic [BLK_W-1:0]  nxt_blk,
   input  logic              nxt_first,
   input  logic              cur_finish,
   output logic              xfer_busy,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [WORD_W-1:0] mem_rd_data,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [WORD_W-1:0] mem_wr_data,
   output logic              flush_valid,
   output logic [BANK_W-1:0] flush_bank,
   output logic [WORD_W-1:0] flush_data
);
   localparam int XFER_WORDS = NUM_BANKS * BANK_WORDS;

   if (XFER_WORDS + 1 > STRIPE_CYCLES) begin : g_bad_stripe
      $error("transfer does not fit in a stripe period");
   end
   if (ADDR_W < need_bits(NUM_BLOCKS * XFER_WORDS)) begin : g_bad_addr
      $error("ADDR_W too small for all block regions");
   end
   if ((1 << BLK_W) < NUM_BLOCKS) begin : g_bad_blk
      $error("BLK_W too small for NUM_BLOCKS");
   end

   logic              act_sel, sh_en, use_init;
   logic [BANK_W-1:0] sh_bank;
   logic [WIDX_W-1:0] sh_word;
   logic [WORD_W-1:0] sh_in, head_sel;
   logic [WORD_W-1:0] bank_rd   [NUM_BANKS];
   logic [WORD_W-1:0] bank_head [NUM_BANKS];

   cstate_xfer_seq #(
      .BANKS(NUM_BANKS), .BANK_WORDS(BANK_WORDS), .BLK_W(BLK_W),
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .WIDX_W(WIDX_W)
   ) seq_i (
      .clk(clk), .rst_n(rst_n),
      .sw_req(blk_switch), .ld_idx(nxt_blk), .ld_first(nxt_first),
      .st_finish(cur_finish), .busy(xfer_busy), .act_sel(act_sel),
      .sh_en(sh_en), .sh_bank(sh_bank), .sh_word(sh_word), .use_init(use_init),
      .rd_en(mem_rd_en), .rd_addr(mem_rd_addr),
      .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .flush_valid(flush_valid)
   );

   assign sh_in = use_init ? ((sh_word == '0) ? INIT_HEAD : '0) : mem_rd_data;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      cstate_bank #(.WORD_W(WORD_W), .BANK_WORDS(BANK_WORDS), .WIDX_W(WIDX_W)) bank_i (
         .clk(clk), .rst_n(rst_n), .act_sel(act_sel),
         .wr_en(cdr_wr_en && (cdr_wr_bank == BANK_W'(b))),
         .wr_word(cdr_wr_word), .wr_data(cdr_wr_data),
         .rd_word(cdr_rd_word), .rd_data(bank_rd[b]),
         .sh_en(sh_en && (sh_bank == BANK_W'(b))),
         .sh_in(sh_in), .head(bank_head[b])
      );
   end

   assign cdr_rd_data = (32'(cdr_rd_bank) < NUM_BANKS) ? bank_rd[cdr_rd_bank] : '0;
   assign head_sel    = (32'(sh_bank) < NUM_BANKS) ? bank_head[sh_bank] : '0;
   assign mem_wr_data = head_sel;
   assign flush_data  = head_sel;
   assign flush_bank  = sh_bank;
endmodule

// File: rtl/coder_state_swap_chk.sv
module coder_state_swap_chk #(
   parameter int ADDR_W     = 12,
   parameter int XFER_WORDS = 250
) (
   input logic              clk,
   input logic              rst_n,
   input logic              blk_switch,
   input logic              xfer_busy,
   input logic              act_sel,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_wr_en,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic              flush_valid
);
   int unsigned busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy_run <= 0;
      else if (xfer_busy) busy_run <= busy_run + 1;
      else                busy_run <= 0;
   end

   // R1
   rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en || mem_wr_en) |-> xfer_busy);
   // R3
   sw_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_busy |=> $stable(act_sel));
   // R5
   start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_switch && !xfer_busy) |=> xfer_busy);
   // R5
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_busy |-> (busy_run <= XFER_WORDS));
   // R6
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + 1'b1));
   // R7
   wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && $past(mem_wr_en)) |-> (mem_wr_addr == $past(mem_wr_addr) + 1'b1));
   // R9
   flush_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> !mem_wr_en);
   // R9
   flush_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> !flush_valid);
endmodule

bind coder_state_swap coder_state_swap_chk #(
   .ADDR_W(ADDR_W), .XFER_WORDS(NUM_BANKS * BANK_WORDS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .blk_switch(blk_switch), .xfer_busy(xfer_busy),
   .act_sel(act_sel), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
   .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .flush_valid(flush_valid)
);

// File: tb/coder_state_swap_tb_top.sv
module coder_state_swap_tb_top;
   localparam int XFER = 250;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cdr_wr_en = 1'b0;
   logic [3:0]  cdr_wr_bank = '0;
   logic [4:0]  cdr_wr_word = '0;
   logic [15:0] cdr_wr_data = '0;
   logic [3:0]  cdr_rd_bank = '0;
   logic [4:0]  cdr_rd_word = '0;
   logic [15:0] cdr_rd_data;
   logic        blk_switch = 1'b0;
   logic [3:0]  nxt_blk = '0;
   logic        nxt_first = 1'b0;
   logic        cur_finish = 1'b0;
   logic        xfer_busy, mem_rd_en, mem_wr_en, flush_valid;
   logic [11:0] mem_rd_addr, mem_wr_addr;
   logic [15:0] mem_rd_data, mem_wr_data, flush_data;
   logic [3:0]  flush_bank;

   int n_tests = 0;
   int n_fail  = 0;
   int rd_cnt, wr_cnt, fl_cnt;
   logic [3:0]  fl_bank_log [10];
   logic [15:0] fl_data_log [10];
   logic [15:0] mem [4096];

   always #4 clk = ~clk;

   coder_state_swap dut_i (.*);

   function automatic logic [15:0] pat(input int a);
      return 16'((a * 37) ^ 16'h5A00);
   endfunction

   initial for (int a = 0; a < 4096; a++) mem[a] = pat(a);

   always @(posedge clk) begin
      if (mem_rd_en) begin mem_rd_data <= mem[mem_rd_addr]; rd_cnt <= rd_cnt + 1; end
      if (mem_wr_en) begin mem[mem_wr_addr] <= mem_wr_data; wr_cnt <= wr_cnt + 1; end
      if (flush_valid) begin
         if (fl_cnt < 10) begin
            fl_bank_log[fl_cnt] <= flush_bank;
            fl_data_log[fl_cnt] <= flush_data;
         end
         fl_cnt <= fl_cnt + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cdr_read(input int b, input int w, output logic [15:0] d);
      cdr_rd_bank = 4'(b); cdr_rd_word = 5'(w);
      #1 d = cdr_rd_data;
   endtask

   task automatic cdr_write(input int b, input int w, input logic [15:0] d);
      @(negedge clk);
      cdr_wr_en = 1'b1; cdr_wr_bank = 4'(b); cdr_wr_word = 5'(w); cdr_wr_data = d;
      @(negedge clk);
      cdr_wr_en = 1'b0;
   endtask

   // Switch, optionally pulsing a second strobe at busy cycle 100; returns busy length
   task automatic do_switch(input int blk, input logic first, input logic fin,
                            input logic extra, output int len);
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0; fl_cnt = 0;
      blk_switch = 1'b1; nxt_blk = 4'(blk); nxt_first = first; cur_finish = fin;
      @(negedge clk);
      blk_switch = 1'b0;
      len = 0;
      while (xfer_busy && len < 400) begin
         len++;
         if (extra && len == 100) begin
            blk_switch = 1'b1; nxt_blk = 4'd5; nxt_first = 1'b1; cur_finish = 1'b1;
         end else begin
            blk_switch = 1'b0;
         end
         @(negedge clk);
      end
      blk_switch = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      check("R1 busy", 32'(xfer_busy), 0);
      check("R1 rd_en", 32'(mem_rd_en), 0);
      check("R1 wr_en", 32'(mem_wr_en), 0);
      check("R1 flush", 32'(flush_valid), 0);
      cdr_read(7, 13, d);
      check("R1 coder read", 32'(d), 0);
   endtask

   task automatic t_coder_rw();
      logic [15:0] d;
      cdr_write(3, 7, 16'h1234);
      cdr_read(3, 7, d);  check("R2 readback", 32'(d), 32'h1234);
      cdr_read(4, 7, d);  check("R2 other bank", 32'(d), 0);
   endtask

   task automatic t_first_load();
      int len;
      logic [15:0] d;
      do_switch(2, 1'b1, 1'b0, 1'b0, len);
      check("R5 busy length", 32'(len), 251);
      check("R8 no reads", 32'(rd_cnt), 0);
      check("R10 no writes", 32'(wr_cnt), 0);
      check("R10 no flush", 32'(fl_cnt), 0);
      cdr_read(3, 7, d);  check("R4 not yet swapped", 32'(d), 0);
      do_switch(1, 1'b0, 1'b0, 1'b0, len);
      check("R6 read count", 32'(rd_cnt), XFER);
      check("R10 invalid copy not stored", 32'(wr_cnt), 0);
      cdr_read(0, 0, d);  check("R8 bank0 head", 32'(d), 32'h8000);
      cdr_read(5, 0, d);  check("R8 bank5 head", 32'(d), 32'h8000);
      cdr_read(5, 3, d);  check("R8 bank5 word3", 32'(d), 0);
      cdr_read(3, 7, d);  check("R4 old coder write gone", 32'(d), 0);
   endtask

   task automatic t_store_and_ignore();
      int len;
      logic [15:0] d;
      cdr_write(4, 9, 16'hBEEF);
      do_switch(3, 1'b0, 1'b0, 1'b1, len);
      check("R3 transfer not restarted", 32'(len), 251);
      check("R7 write count", 32'(wr_cnt), XFER);
      check("R7 modified word stored", 32'(mem[500 + 4*25 + 9]), 32'hBEEF);
      check("R7 head stored", 32'(mem[500]), 32'h8000);
      check("R7 word1 stored", 32'(mem[501]), 0);
      cdr_read(0, 0, d);  check("R4 block1 bank0 w0", 32'(d), 32'(pat(250)));
      cdr_read(6, 17, d); check("R6 block1 bank6 w17", 32'(d), 32'(pat(250 + 6*25 + 17)));
      cdr_read(9, 24, d); check("R6 block1 last word", 32'(d), 32'(pat(499)));
   endtask

   task automatic t_mid_read();
      logic [15:0] d;
      int len;
      cdr_write(2, 0, 16'h7777);
      fork
         do_switch(0, 1'b1, 1'b1, 1'b0, len);
         begin
            repeat (60) @(negedge clk);
            cdr_read(1, 3, d);
            check("R11 active steady mid-transfer", 32'(d), 32'(pat(750 + 25 + 3)));
         end
      join
      check("R9 no writes", 32'(wr_cnt), 0);
      check("R9 flush count", 32'(fl_cnt), 10);
      for (int b = 0; b < 10; b++)
         check("R9 flush bank order", 32'(fl_bank_log[b]), 32'(b));
      check("R9 flush data bank2", 32'(fl_data_log[2]), 32'h7777);
      check("R9 flush data bank7", 32'(fl_data_log[7]), 32'(pat(250 + 7*25)));
      check("R9 region untouched", 32'(mem[250 + 50]), 32'(pat(300)));
      cdr_read(9, 24, d); check("R4 block3 last word", 32'(d), 32'(pat(999)));
   endtask

   initial begin
      rd_cnt = 0; wr_cnt = 0; fl_cnt = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_coder_rw();
      t_first_load();
      t_store_and_ignore();
      t_mid_read();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 20000);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule